// File: doc/BRIEF.md
# Serial Port Bridge for an 8-bit Processor Bus

This block puts an asynchronous serial receiver and transmitter, each with its own FIFO, behind the I/O strobes, flag inputs, interrupt line and DMA-in request of a small 8-bit processor. The processor does not need a memory-mapped register window. It reads received bytes with an input instruction and sends bytes with an output instruction. It polls FIFO state and a front-panel write button through active-low flag lines, and it takes an interrupt when work is waiting.

A two-bit mode input selects how received bytes are used. In load mode the bridge copies each incoming byte into memory itself. It raises the DMA-in request and holds it until the processor grants the cycle, so a program image can be streamed in over the serial line with no software running. In run and single-step modes the received bytes stay in the receive FIFO until the program reads them.

Top module: `serbus_bridge`

## Requirements
- R1: After reset, `ef_n_o` is 4'b1111, `irq_o`, `dma_req_o` and `rd_data_o` are 0, and `txd_o` idles high.
- R2: A frame on `rxd_i` has a low start bit, 8 data bits sent least significant bit first and a high stop bit, with each bit lasting CLK_DIV clocks. The receiver samples each bit near its middle, and every accepted frame enters the receive FIFO once, in arrival order.
- R3: A frame whose stop bit samples low is discarded. The receiver accepts no new start bit until the line has returned high.
- R4: In run (2'b01) or single-step (2'b10) mode, a one-cycle `inp_stb_i` with `port_sel_i` equal to RX_PORT (default 1) loads the head byte of the receive FIFO onto `rd_data_o` on the next clock and removes that byte. A strobe on any other port changes neither `rd_data_o` nor the FIFO.
- R5: An input strobe on RX_PORT while the receive FIFO is empty sets `rd_data_o` to 0x00 and leaves the FIFO empty. Later bytes still arrive in order.
- R6: `ef_n_o[1]` is low exactly while the receive FIFO holds at least one byte. It lags the FIFO by one clock.
- R7: A one-cycle `out_stb_i` with `port_sel_i` equal to TX_PORT (default 1) queues `bus_i` for transmission. Queued bytes leave on `txd_o` in order, using the framing of R2.
- R8: `ef_n_o[0]` is low while the transmit FIFO is full. An output strobe that finds the FIFO full is discarded.
- R9: `btn_i` is synchronized and must stay at a new level for DEBOUNCE clocks before it is accepted. `ef_n_o[3]` is low while the accepted level is pressed, and `ef_n_o[2]` is always high.
- R10: `irq_o` is high one clock after the receive FIFO is non-empty or the accepted button level is pressed, and low otherwise.
- R11: In load mode (2'b00), each received byte is presented on `dma_data_o` with `dma_req_o` held high and stable until a clock with `dma_ack_i` high. The request then drops, and each byte is delivered exactly once, in order. Input strobes are ignored in load mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 load, 01 run, 10 single-step, 11 treated as run |
| port_sel_i | input | 3 | I/O port number of the current I/O instruction |
| inp_stb_i | input | 1 | One-cycle input-instruction strobe |
| out_stb_i | input | 1 | One-cycle output-instruction strobe |
| bus_i | input | 8 | Data byte written by an output instruction |
| rd_data_o | output | 8 | Byte returned to an input instruction |
| ef_n_o | output | 4 | Active-low flags: [0] TX full, [1] RX data, [2] unused high, [3] button |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA-in request |
| dma_ack_i | input | 1 | DMA-in cycle granted |
| dma_data_o | output | 8 | Byte for the DMA-in cycle |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| btn_i | input | 1 | Raw write-button level, high when pressed |

## Verification
The hardest case to reach is the full transmit FIFO, because the transmitter drains bytes on its own. To get there, the bench issues output strobes on consecutive clocks, two more than the FIFO depth plus the one byte already taken by the transmitter. The flag is checked before the first frame ends, and the decoded serial stream must show exactly the accepted bytes. The DMA hand-off is also hard to reach from the ports. The bench holds back the grant while a byte waits and issues a stray input strobe during that wait. It then grants with varying delays so that a new byte arrives while an earlier request is still pending.

// File: rtl/serbus_pkg.sv
package serbus_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] MODE_LOAD = 2'b00;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_SHIFT} tx_state_e;
  typedef enum logic {DMA_IDLE, DMA_WAIT} dma_state_e;
endpackage

// File: rtl/serbus_fifo.sv
module serbus_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o <= '0;
    end else if (pop_i) begin
      dout_o <= empty_o ? '0 : mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= advance(wr_ptr);
      if (do_pop)  rd_ptr <= advance(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    (push_i && full_o && !pop_i) |=> (full_o && $stable(wr_ptr)));
  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (pop_i && empty_o && !push_i) |=> (empty_o && dout_o == '0));
endmodule

// File: rtl/serbus_rx.sv
module serbus_rx
  import serbus_pkg::*;
#(
  parameter int CLK_DIV = 69
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int CW = $clog2(CLK_DIV + 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(CLK_DIV / 2);

  logic [1:0]        sync;
  logic              line;
  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        bitn;
  logic [BYTE_W-1:0] shreg;

  assign line = sync[1];

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (state)
        RX_IDLE: if (!line) begin
          cnt   <= HALF_LAST;
          state <= RX_START;
        end
        RX_START: if (cnt == '0) begin
          if (!line) begin
            cnt   <= BIT_LAST;
            bitn  <= '0;
            state <= RX_DATA;
          end else begin
            state <= RX_IDLE;
          end
        end else cnt <= cnt - 1'b1;
        RX_DATA: if (cnt == '0) begin
          shreg <= {line, shreg[BYTE_W-1:1]};
          cnt   <= BIT_LAST;
          if (bitn == 3'd7) state <= RX_STOP;
          else              bitn  <= bitn + 1'b1;
        end else cnt <= cnt - 1'b1;
        RX_STOP: if (cnt == '0) begin
          if (line) begin
            data_o  <= shreg;
            valid_o <= 1'b1;
            state   <= RX_IDLE;
          end else begin
            state <= RX_BREAK;
          end
        end else cnt <= cnt - 1'b1;
        RX_BREAK: if (line) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_bad_stop_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (state == RX_STOP && cnt == '0 && !line) |=> (!valid_o && state == RX_BREAK));
endmodule

// File: rtl/serbus_tx.sv
module serbus_tx
  import serbus_pkg::*;
#(
  parameter int CLK_DIV = 69
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_empty_i,
  input  logic [BYTE_W-1:0] fifo_dout_i,
  output logic              fifo_pop_o,
  output logic              txd_o
);
  localparam int CW = $clog2(CLK_DIV + 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(CLK_DIV - 1);

  tx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [3:0]      left;
  logic [BYTE_W:0] shreg;

  assign fifo_pop_o = (state == TX_IDLE) && !fifo_empty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      cnt   <= '0;
      left  <= '0;
      shreg <= '1;
      txd_o <= 1'b1;
    end else begin
      case (state)
        TX_IDLE: if (!fifo_empty_i) state <= TX_LOAD;
        TX_LOAD: begin
          txd_o <= 1'b0;
          shreg <= {1'b1, fifo_dout_i};
          cnt   <= BIT_LAST;
          left  <= 4'd9;
          state <= TX_SHIFT;
        end
        TX_SHIFT: if (cnt == '0) begin
          if (left == '0) begin
            state <= TX_IDLE;
          end else begin
            txd_o <= shreg[0];
            shreg <= {1'b1, shreg[BYTE_W:1]};
            left  <= left - 1'b1;
            cnt   <= BIT_LAST;
          end
        end else cnt <= cnt - 1'b1;
        default: state <= TX_IDLE;
      endcase
    end
  end

  assert_bit_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state == TX_SHIFT && cnt != '0) |=> $stable(txd_o));
  assert_idle_line_high_R7: assert property (@(posedge clk) disable iff (rst)
    (state == TX_IDLE) |-> txd_o);
endmodule

// File: rtl/serbus_debounce.sv
module serbus_debounce #(
  parameter int DEBOUNCE = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = $clog2(DEBOUNCE + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE - 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync    <= '0;
      cnt     <= '0;
      level_o <= 1'b0;
    end else begin
      sync <= {sync[0], raw_i};
      if (sync[1] == level_o) begin
        cnt <= '0;
      end else if (cnt == CNT_LAST) begin
        level_o <= sync[1];
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_level_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (sync[1] == level_o) |=> $stable(level_o));
endmodule

// File: rtl/serbus_bridge.sv
module serbus_bridge
  import serbus_pkg::*;
#(
  parameter int CLK_DIV    = 69,
  parameter int FIFO_DEPTH = 16,
  parameter int DEBOUNCE   = 1024,
  parameter int RX_PORT    = 1,
  parameter int TX_PORT    = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic [2:0] port_sel_i,
  input  logic       inp_stb_i,
  input  logic       out_stb_i,
  input  logic [7:0] bus_i,
  output logic [7:0] rd_data_o,
  output logic [3:0] ef_n_o,
  output logic       irq_o,
  output logic       dma_req_o,
  input  logic       dma_ack_i,
  output logic [7:0] dma_data_o,
  input  logic       rxd_i,
  output logic       txd_o,
  input  logic       btn_i
);
  localparam logic [2:0] RX_SEL = 3'(RX_PORT);
  localparam logic [2:0] TX_SEL = 3'(TX_PORT);

  logic              load_mode;
  logic              rx_valid, rx_pop, rx_empty, rx_full;
  logic [BYTE_W-1:0] rx_byte, rx_head;
  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic [BYTE_W-1:0] tx_head;
  logic              btn_lvl;
  logic              inp_hit, dma_fetch;
  dma_state_e        dma_st;

  assign load_mode = (mode_i == MODE_LOAD);
  assign inp_hit   = inp_stb_i && (port_sel_i == RX_SEL) && !load_mode && (dma_st == DMA_IDLE);
  assign dma_fetch = load_mode && (dma_st == DMA_IDLE) && !rx_empty;
  assign rx_pop    = inp_hit || dma_fetch;
  assign tx_push   = out_stb_i && (port_sel_i == TX_SEL);

  serbus_rx #(.CLK_DIV(CLK_DIV)) u_rx (
    .clk(clk), .rst(rst), .rxd_i(rxd_i), .valid_o(rx_valid), .data_o(rx_byte));

  serbus_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .push_i(rx_valid), .din_i(rx_byte), .pop_i(rx_pop),
    .dout_o(rx_head), .empty_o(rx_empty), .full_o(rx_full));

  serbus_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .push_i(tx_push), .din_i(bus_i), .pop_i(tx_pop),
    .dout_o(tx_head), .empty_o(tx_empty), .full_o(tx_full));

  serbus_tx #(.CLK_DIV(CLK_DIV)) u_tx (
    .clk(clk), .rst(rst), .fifo_empty_i(tx_empty), .fifo_dout_i(tx_head),
    .fifo_pop_o(tx_pop), .txd_o(txd_o));

  serbus_debounce #(.DEBOUNCE(DEBOUNCE)) u_btn (
    .clk(clk), .rst(rst), .raw_i(btn_i), .level_o(btn_lvl));

  assign rd_data_o  = rx_head;
  assign dma_data_o = rx_head;

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_st    <= DMA_IDLE;
      dma_req_o <= 1'b0;
    end else begin
      case (dma_st)
        DMA_IDLE: if (dma_fetch) begin
          dma_st    <= DMA_WAIT;
          dma_req_o <= 1'b1;
        end
        DMA_WAIT: if (dma_ack_i) begin
          dma_st    <= DMA_IDLE;
          dma_req_o <= 1'b0;
        end
        default: dma_st <= DMA_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ef_n_o <= 4'b1111;
      irq_o  <= 1'b0;
    end else begin
      ef_n_o <= {~btn_lvl, 1'b1, rx_empty, ~tx_full};
      irq_o  <= !rx_empty || btn_lvl;
    end
  end

  assert_dma_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (dma_req_o && !dma_ack_i) |=> (dma_req_o && $stable(dma_data_o)));
  assert_dma_release_R11: assert property (@(posedge clk) disable iff (rst)
    (dma_req_o && dma_ack_i) |=> !dma_req_o);
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (!rx_empty || btn_lvl) |=> irq_o);
  assert_rx_flag_R6: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> ef_n_o[1]);
  assert_rx_full_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rx_pop) |=> rx_full);
endmodule

// File: tb/serbus_bridge_test.sv
`timescale 1ns/1ps
module serbus_bridge_test;
  localparam int DIV   = 69;
  localparam int DEPTH = 8;
  localparam int DEB   = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_i = 2'b01;
  logic [2:0] port_sel_i = 3'd0;
  logic inp_stb_i = 1'b0, out_stb_i = 1'b0;
  logic [7:0] bus_i = 8'h00;
  logic [7:0] rd_data_o, dma_data_o;
  logic [3:0] ef_n_o;
  logic irq_o, dma_req_o, txd_o;
  logic dma_ack_i = 1'b0;
  logic rxd_i = 1'b1;
  logic btn_i = 1'b0;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  bit resp_en = 1'b0;
  logic [7:0] rx_model[$];
  logic [7:0] dma_exp[$], dma_got[$];
  logic [7:0] tx_exp[$], tx_got[$];
  logic [7:0] last_rd = 8'h00;

  always #4 clk = ~clk;

  serbus_bridge #(.CLK_DIV(DIV), .FIFO_DEPTH(DEPTH), .DEBOUNCE(DEB)) uut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .port_sel_i(port_sel_i),
    .inp_stb_i(inp_stb_i), .out_stb_i(out_stb_i), .bus_i(bus_i),
    .rd_data_o(rd_data_o), .ef_n_o(ef_n_o), .irq_o(irq_o),
    .dma_req_o(dma_req_o), .dma_ack_i(dma_ack_i), .dma_data_o(dma_data_o),
    .rxd_i(rxd_i), .txd_o(txd_o), .btn_i(btn_i));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit good, input bit to_dma);
    @(negedge clk) rxd_i = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_i = b[i];
      repeat (DIV) @(negedge clk);
    end
    rxd_i = good;
    repeat (DIV) @(negedge clk);
    rxd_i = 1'b1;
    if (!good) repeat (DIV) @(negedge clk);
    repeat (4) @(negedge clk);
    if (good) begin
      if (to_dma) dma_exp.push_back(b);
      else if (rx_model.size() < DEPTH) rx_model.push_back(b);
    end
  endtask

  task automatic do_inp(input logic [2:0] port);
    @(negedge clk);
    port_sel_i = port;
    inp_stb_i  = 1'b1;
    @(negedge clk);
    inp_stb_i  = 1'b0;
    if (port == 3'd1 && mode_i != 2'b00)
      last_rd = (rx_model.size() > 0) ? rx_model.pop_front() : 8'h00;
  endtask

  task automatic check_rx_flags(input string req);
    repeat (2) @(negedge clk);
    check(req, "EF2 vs model", {31'd0, ef_n_o[1]}, {31'd0, rx_model.size() == 0});
    check(req, "irq vs model", {31'd0, irq_o}, {31'd0, rx_model.size() != 0});
  endtask

  // serial monitor on txd_o
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (!rst && txd_o == 1'b0) begin
        repeat (DIV / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          b[i] = txd_o;
        end
        repeat (DIV) @(negedge clk);
        check("R7", "stop bit", {31'd0, txd_o}, 32'd1);
        tx_got.push_back(b);
      end
    end
  end

  // DMA grant responder with varying delay
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (resp_en && dma_req_o) begin
        repeat (dly) @(negedge clk);
        dma_got.push_back(dma_data_o);
        dma_ack_i = 1'b1;
        @(negedge clk) dma_ack_i = 1'b0;
        dly = (dly + 1) % 3;
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "ef_n", {28'd0, ef_n_o}, 32'hF);
    check("R1", "irq", {31'd0, irq_o}, 32'd0);
    check("R1", "dma_req", {31'd0, dma_req_o}, 32'd0);
    check("R1", "txd idle", {31'd0, txd_o}, 32'd1);
    check("R1", "rd_data", {24'd0, rd_data_o}, 32'd0);

    // R2 receive in run mode, R6 and R10 flag/irq raise
    mode_i = 2'b01;
    send_byte(8'h5A, 1'b1, 1'b0);
    send_byte(8'hC3, 1'b1, 1'b0);
    check_rx_flags("R6");
    check_rx_flags("R10");
    // R4 other port ignored
    do_inp(3'd2);
    check("R4", "other port rd", {24'd0, rd_data_o}, {24'd0, last_rd});
    check_rx_flags("R4");
    // R4 and R2 head read and pop, in order
    do_inp(3'd1);
    check("R2", "first byte", {24'd0, rd_data_o}, {24'd0, last_rd});
    do_inp(3'd1);
    check("R4", "second byte", {24'd0, rd_data_o}, {24'd0, last_rd});
    check_rx_flags("R6");
    // R5 read from empty FIFO
    do_inp(3'd1);
    check("R5", "empty read", {24'd0, rd_data_o}, 32'h00);
    check_rx_flags("R5");
    // R4 single-step mode, order still preserved after empty read
    mode_i = 2'b10;
    send_byte(8'h96, 1'b1, 1'b0);
    do_inp(3'd1);
    check("R5", "byte after empty read", {24'd0, rd_data_o}, {24'd0, last_rd});
    check("R4", "step mode value", {24'd0, rd_data_o}, 32'h96);
    check_rx_flags("R4");

    // R3 bad stop bit discarded, then recovery
    mode_i = 2'b01;
    send_byte(8'hA5, 1'b0, 1'b0);
    check_rx_flags("R3");
    send_byte(8'h1F, 1'b1, 1'b0);
    do_inp(3'd1);
    check("R3", "byte after bad frame", {24'd0, rd_data_o}, 32'h1F);

    // R7 transmit
    foreach (tx_exp[i]) tx_exp.delete(i);
    for (int i = 0; i < 3; i++) begin
      logic [7:0] v;
      v = 8'h55 ^ 8'(i * 8'h5A);
      @(negedge clk);
      port_sel_i = 3'd1; bus_i = v; out_stb_i = 1'b1;
      tx_exp.push_back(v);
    end
    @(negedge clk) out_stb_i = 1'b0;
    repeat (3 * 10 * DIV + 200) @(negedge clk);
    check("R7", "tx count", tx_got.size(), tx_exp.size());
    for (int i = 0; i < tx_exp.size() && i < tx_got.size(); i++)
      check("R7", "tx byte", {24'd0, tx_got[i]}, {24'd0, tx_exp[i]});

    // R8 full transmit FIFO, extra pushes dropped
    tx_got.delete();
    tx_exp.delete();
    for (int i = 0; i < DEPTH + 3; i++) begin
      @(negedge clk);
      port_sel_i = 3'd1; bus_i = 8'(8'h10 + i); out_stb_i = 1'b1;
      if (i < DEPTH + 1) tx_exp.push_back(8'(8'h10 + i));
    end
    @(negedge clk) out_stb_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", "EF1 full", {31'd0, ef_n_o[0]}, 32'd0);
    repeat ((DEPTH + 1) * 10 * DIV + 300) @(negedge clk);
    check("R8", "EF1 after drain", {31'd0, ef_n_o[0]}, 32'd1);
    check("R8", "tx accepted count", tx_got.size(), tx_exp.size());
    for (int i = 0; i < tx_exp.size() && i < tx_got.size(); i++)
      check("R8", "tx byte", {24'd0, tx_got[i]}, {24'd0, tx_exp[i]});

    // R9 and R10 button
    btn_i = 1'b1;
    repeat (DEB / 2) @(negedge clk);
    btn_i = 1'b0;
    repeat (DEB + 10) @(negedge clk);
    check("R9", "glitch ignored", {31'd0, ef_n_o[3]}, 32'd1);
    check("R10", "irq after glitch", {31'd0, irq_o}, 32'd0);
    btn_i = 1'b1;
    repeat (DEB + 10) @(negedge clk);
    check("R9", "pressed", {31'd0, ef_n_o[3]}, 32'd0);
    check("R10", "irq on button", {31'd0, irq_o}, 32'd1);
    check("R9", "EF3 unused high", {31'd0, ef_n_o[2]}, 32'd1);
    btn_i = 1'b0;
    repeat (DEB + 10) @(negedge clk);
    check("R9", "released", {31'd0, ef_n_o[3]}, 32'd1);
    check("R10", "irq released", {31'd0, irq_o}, 32'd0);

    // R11 load mode with held grant
    mode_i = 2'b00;
    send_byte(8'h3C, 1'b1, 1'b1);
    check("R11", "req held", {31'd0, dma_req_o}, 32'd1);
    check("R11", "dma data", {24'd0, dma_data_o}, 32'h3C);
    do_inp(3'd1);
    @(negedge clk);
    check("R11", "inp ignored req", {31'd0, dma_req_o}, 32'd1);
    check("R11", "inp ignored data", {24'd0, rd_data_o}, 32'h3C);
    resp_en = 1'b1;
    send_byte(8'h81, 1'b1, 1'b1);
    send_byte(8'h7E, 1'b1, 1'b1);
    send_byte(8'h00, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    check("R11", "dma count", dma_got.size(), dma_exp.size());
    for (int i = 0; i < dma_exp.size() && i < dma_got.size(); i++)
      check("R11", "dma byte", {24'd0, dma_got[i]}, {24'd0, dma_exp[i]});
    check("R11", "req released", {31'd0, dma_req_o}, 32'd0);
    check("R11", "EF2 empty after load", {31'd0, ef_n_o[1]}, 32'd1);
    resp_en = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule